// File: doc/BRIEF.md
# Load Ordering Violation Detector

This block finds loads that read memory ahead of an older load or store touching the same coarse address block. When a memory instruction executes, the pipeline presents a scan request with a start index into the circular load queue and the executing address. The block then walks the load queue one entry per clock toward the queue tail. It compares each entry's address, with the low offset bits removed, against the executing address. The queue contents come in as flat vectors: an address-valid flag, an address and a sequence number for each slot.

An executing load starts its walk at the slot after its own. An executing store starts at the load-queue slot it recorded when it was dispatched. On a qualifying hit the block keeps the offending load in a single held-violator register, counts the event and flags a fault back to the executing instruction. The pipeline later reads the held violator and clears it in the same action. A squash to an older sequence number discards the held violator. A load whose address generation faulted skips the walk.

Top module: `mem_order_guard`

## Requirements
- R1: After reset, busy, done, fault_out and held_valid are 0 and viol_count is 0.
- R2: For a load request the walk begins at slot req_idx+1, wrapping from DEPTH-1 to 0. For a store request it begins at slot req_idx itself. A conflicting load in a load's own slot is never reported.
- R3: The walk ends at slot lq_tail, which is not examined. A conflicting entry at or beyond the tail is never reported.
- R4: An entry conflicts only if its address-valid flag is 1 and its address shifted right by BLK_SHIFT (8) bits equals the request address shifted the same way. Addresses that differ only in the low 8 bits conflict.
- R5: On the first conflicting entry, the walk records it if no violator is held or the entry's sequence number is strictly smaller than the held one. Otherwise the walk stops, reports no fault and leaves the held violator unchanged. Later entries are not examined.
- R6: A recorded violation sets fault_out together with done. On the same edge it loads the entry's slot and sequence number into the held register and adds one to viol_count.
- R7: While rd_en is 1, held_valid, held_idx and held_seq show the held violator. On that clock edge the register is cleared.
- R8: A squash with sequence number S clears the held violator if S is strictly smaller than held_seq. Otherwise the held violator is kept.
- R9: A load request with req_ld_fault set does no walk. Done rises on the edge that samples the request, with fault_out 0 and nothing recorded. For store requests req_ld_fault has no effect.
- R10: One slot is examined per clock. Done is a one-cycle pulse on the k-th rising edge counted from the one that samples the request, where k = 2 + the number of slots passed over. Busy is 1 while walking.
- R11: When a violation is recorded on the same edge as a read or a qualifying squash, the newly recorded violator is held afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a scan (only while busy is 0) |
| req_is_store | input | 1 | 1: executing store, 0: executing load |
| req_idx | input | IW | Load's own slot, or the load slot recorded with the store |
| req_addr | input | AW | Executing instruction's address |
| req_ld_fault | input | 1 | The load faulted during address generation |
| lq_tail | input | IW | Load-queue tail slot |
| lq_addr_ok | input | DEPTH | Address-valid flag per slot |
| lq_addr | input | DEPTH*AW | Addresses, slot i at bits [i*AW +: AW] |
| lq_seq | input | DEPTH*SW | Sequence numbers, slot i at bits [i*SW +: SW] |
| rd_en | input | 1 | Read and clear the held violator |
| squash_valid | input | 1 | Squash event |
| squash_seq | input | SW | Squash sequence number |
| busy | output | 1 | Scan in progress |
| done | output | 1 | Scan finished (one-cycle pulse) |
| fault_out | output | 1 | Violation recorded for this request (valid with done) |
| held_valid | output | 1 | A violator is held |
| held_idx | output | IW | Held violator's slot |
| held_seq | output | SW | Held violator's sequence number |
| viol_count | output | CW | Recorded violation count |

## Verification
The assertions take for granted that a request arrives only while busy is low and that req_idx names a real slot. They also assume lq_tail and the queue vectors stay still while a walk is in progress. The bench honours this by changing the queue arrays only between requests, waiting for done before the next request, and drawing slot numbers modulo the queue depth. Random rounds draw addresses from a few blocks with random low bits so that conflicts, older-held stops and tail endings all occur often. Reads and squashes are interleaved between requests, and one directed case lines a read up with the recording edge.

// File: rtl/mog_pkg.sv
package mog_pkg;
   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_WALK = 1'b1
   } walk_state_t;

   typedef enum logic [1:0] {
      VERDICT_PASS   = 2'd0,
      VERDICT_RECORD = 2'd1,
      VERDICT_YIELD  = 2'd2
   } verdict_t;
endpackage

// File: rtl/mog_ring_step.sv
module mog_ring_step #(
   parameter int DEPTH = 16,
   localparam int IW = $clog2(DEPTH)
) (
   input  logic [IW-1:0] idx,
   output logic [IW-1:0] idx_next
);
   localparam bit IS_POW2 = (DEPTH == (1 << IW));

   generate
      if (IS_POW2) begin : g_pow2
         assign idx_next = idx + 1'b1;
      end else begin : g_mod
         assign idx_next = (idx == IW'(DEPTH - 1)) ? '0 : idx + 1'b1;
      end
   endgenerate
endmodule

// File: rtl/mog_entry_cmp.sv
module mog_entry_cmp
   import mog_pkg::*;
#(
   parameter int AW        = 32,
   parameter int SW        = 16,
   parameter int BLK_SHIFT = 8
) (
   input  logic          ent_ok,
   input  logic [AW-1:0] ent_addr,
   input  logic [SW-1:0] ent_seq,
   input  logic [AW-1:0] ref_addr,
   input  logic          held_valid,
   input  logic [SW-1:0] held_seq,
   output verdict_t      verdict
);
   logic blk_hit;
   logic older;

   assign blk_hit = ent_ok && ((ent_addr >> BLK_SHIFT) == (ref_addr >> BLK_SHIFT));
   assign older   = !held_valid || (ent_seq < held_seq);

   always_comb begin
      if (!blk_hit)   verdict = VERDICT_PASS;
      else if (older) verdict = VERDICT_RECORD;
      else            verdict = VERDICT_YIELD;
   end
endmodule

// File: rtl/mog_walk_ctrl.sv
module mog_walk_ctrl
   import mog_pkg::*;
#(
   parameter int DEPTH     = 16,
   parameter int AW        = 32,
   parameter int SW        = 16,
   parameter int BLK_SHIFT = 8,
   localparam int IW = $clog2(DEPTH)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic                req_is_store,
   input  logic [IW-1:0]       req_idx,
   input  logic [AW-1:0]       req_addr,
   input  logic                req_ld_fault,
   input  logic [IW-1:0]       lq_tail,
   input  logic [DEPTH-1:0]    lq_addr_ok,
   input  logic [DEPTH*AW-1:0] lq_addr,
   input  logic [DEPTH*SW-1:0] lq_seq,
   input  logic                held_valid,
   input  logic [SW-1:0]       held_seq,
   output logic                busy,
   output logic                done,
   output logic                fault_out,
   output logic                rec,
   output logic [IW-1:0]       rec_idx,
   output logic [SW-1:0]       rec_seq
);
   walk_state_t   state;
   logic [IW-1:0] cur;
   logic [AW-1:0] ref_addr;
   logic [IW-1:0] req_next;
   logic [IW-1:0] cur_next;
   logic          at_tail;
   verdict_t      verdict;

   logic [AW-1:0] addr_a [DEPTH];
   logic [SW-1:0] seq_a  [DEPTH];

   genvar g;
   generate
      for (g = 0; g < DEPTH; g++) begin : g_unpack
         assign addr_a[g] = lq_addr[g*AW +: AW];
         assign seq_a[g]  = lq_seq[g*SW +: SW];
      end
   endgenerate

   mog_ring_step #(.DEPTH(DEPTH)) u_step_req (.idx(req_idx), .idx_next(req_next));
   mog_ring_step #(.DEPTH(DEPTH)) u_step_cur (.idx(cur),     .idx_next(cur_next));

   mog_entry_cmp #(.AW(AW), .SW(SW), .BLK_SHIFT(BLK_SHIFT)) u_cmp (
      .ent_ok    (lq_addr_ok[cur]),
      .ent_addr  (addr_a[cur]),
      .ent_seq   (seq_a[cur]),
      .ref_addr  (ref_addr),
      .held_valid(held_valid),
      .held_seq  (held_seq),
      .verdict   (verdict)
   );

   assign busy    = (state == ST_WALK);
   assign at_tail = (cur == lq_tail);
   assign rec     = busy && !at_tail && (verdict == VERDICT_RECORD);
   assign rec_idx = cur;
   assign rec_seq = seq_a[cur];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cur       <= '0;
         ref_addr  <= '0;
         done      <= 1'b0;
         fault_out <= 1'b0;
      end else begin
         done      <= 1'b0;
         fault_out <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  if (req_ld_fault && !req_is_store) begin
                     done <= 1'b1;
                  end else begin
                     state    <= ST_WALK;
                     cur      <= req_is_store ? req_idx : req_next;
                     ref_addr <= req_addr;
                  end
               end
            end
            default: begin
               if (at_tail) begin
                  state <= ST_IDLE;
                  done  <= 1'b1;
               end else if (verdict == VERDICT_RECORD) begin
                  state     <= ST_IDLE;
                  done      <= 1'b1;
                  fault_out <= 1'b1;
               end else if (verdict == VERDICT_YIELD) begin
                  state <= ST_IDLE;
                  done  <= 1'b1;
               end else begin
                  cur <= cur_next;
               end
            end
         endcase
      end
   end

   p_req_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> !busy);
   p_req_idx_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (int'(req_idx) < DEPTH));
   p_tail_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
      busy && $past(busy) |-> $stable(lq_tail));
   p_walk_end_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);
   p_done_not_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   p_fault_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fault_out |-> done);
   p_ld_fault_skip_r9: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !busy && req_ld_fault && !req_is_store |=> done && !fault_out && !busy);
endmodule

// File: rtl/mog_violator_reg.sv
module mog_violator_reg #(
   parameter int IW = 4,
   parameter int SW = 16,
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rec,
   input  logic [IW-1:0] rec_idx,
   input  logic [SW-1:0] rec_seq,
   input  logic          rd_en,
   input  logic          squash_valid,
   input  logic [SW-1:0] squash_seq,
   output logic          held_valid,
   output logic [IW-1:0] held_idx,
   output logic [SW-1:0] held_seq,
   output logic [CW-1:0] viol_count
);
   logic squash_hit;

   assign squash_hit = squash_valid && held_valid && (squash_seq < held_seq);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_valid <= 1'b0;
         held_idx   <= '0;
         held_seq   <= '0;
         viol_count <= '0;
      end else begin
         if (rec) begin
            held_valid <= 1'b1;
            held_idx   <= rec_idx;
            held_seq   <= rec_seq;
            viol_count <= viol_count + 1'b1;
         end else if (rd_en || squash_hit) begin
            held_valid <= 1'b0;
         end
      end
   end

   p_read_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && !rec |=> !held_valid);
   p_squash_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      squash_valid && !rec && held_valid && (squash_seq < held_seq) |=> !held_valid);
   p_squash_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
      squash_valid && !rd_en && !rec && held_valid && !(squash_seq < held_seq) |=> held_valid);
   p_record_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rec |=> held_valid && (held_seq == $past(rec_seq)) && (held_idx == $past(rec_idx)));
   p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rec |=> viol_count == CW'($past(viol_count) + 1'b1));
   p_count_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !rec |=> $stable(viol_count));
endmodule

// File: rtl/mem_order_guard.sv
module mem_order_guard
   import mog_pkg::*;
#(
   parameter int DEPTH     = 16,
   parameter int AW        = 32,
   parameter int SW        = 16,
   parameter int BLK_SHIFT = 8,
   parameter int CW        = 16,
   localparam int IW = $clog2(DEPTH)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic                req_is_store,
   input  logic [IW-1:0]       req_idx,
   input  logic [AW-1:0]       req_addr,
   input  logic                req_ld_fault,
   input  logic [IW-1:0]       lq_tail,
   input  logic [DEPTH-1:0]    lq_addr_ok,
   input  logic [DEPTH*AW-1:0] lq_addr,
   input  logic [DEPTH*SW-1:0] lq_seq,
   input  logic                rd_en,
   input  logic                squash_valid,
   input  logic [SW-1:0]       squash_seq,
   output logic                busy,
   output logic                done,
   output logic                fault_out,
   output logic                held_valid,
   output logic [IW-1:0]       held_idx,
   output logic [SW-1:0]       held_seq,
   output logic [CW-1:0]       viol_count
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("mem_order_guard: DEPTH must be at least 2");
      end
      if (BLK_SHIFT < 0 || BLK_SHIFT >= AW) begin : g_bad_shift
         $error("mem_order_guard: BLK_SHIFT must lie in [0, AW)");
      end
      if (SW < 1 || CW < 1) begin : g_bad_width
         $error("mem_order_guard: SW and CW must be positive");
      end
   endgenerate

   logic          rec;
   logic [IW-1:0] rec_idx;
   logic [SW-1:0] rec_seq;

   mog_walk_ctrl #(
      .DEPTH(DEPTH), .AW(AW), .SW(SW), .BLK_SHIFT(BLK_SHIFT)
   ) u_walk (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_is_store(req_is_store),
      .req_idx     (req_idx),
      .req_addr    (req_addr),
      .req_ld_fault(req_ld_fault),
      .lq_tail     (lq_tail),
      .lq_addr_ok  (lq_addr_ok),
      .lq_addr     (lq_addr),
      .lq_seq      (lq_seq),
      .held_valid  (held_valid),
      .held_seq    (held_seq),
      .busy        (busy),
      .done        (done),
      .fault_out   (fault_out),
      .rec         (rec),
      .rec_idx     (rec_idx),
      .rec_seq     (rec_seq)
   );

   mog_violator_reg #(.IW(IW), .SW(SW), .CW(CW)) u_held (
      .clk         (clk),
      .rst_n       (rst_n),
      .rec         (rec),
      .rec_idx     (rec_idx),
      .rec_seq     (rec_seq),
      .rd_en       (rd_en),
      .squash_valid(squash_valid),
      .squash_seq  (squash_seq),
      .held_valid  (held_valid),
      .held_idx    (held_idx),
      .held_seq    (held_seq),
      .viol_count  (viol_count)
   );

   p_fault_sets_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done && fault_out |-> held_valid);
   p_count_moves_on_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (viol_count != $past(viol_count)) |-> done && fault_out);
endmodule

// File: tb/sim_mem_order_guard.sv
`timescale 1ns/1ps
module sim_mem_order_guard;
   localparam int DEPTH = 16;
   localparam int AW    = 32;
   localparam int SW    = 16;
   localparam int CW    = 16;
   localparam int IW    = 4;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                req_valid = 1'b0;
   logic                req_is_store = 1'b0;
   logic [IW-1:0]       req_idx = '0;
   logic [AW-1:0]       req_addr = '0;
   logic                req_ld_fault = 1'b0;
   logic [IW-1:0]       lq_tail = '0;
   logic [DEPTH-1:0]    lq_addr_ok;
   logic [DEPTH*AW-1:0] lq_addr;
   logic [DEPTH*SW-1:0] lq_seq;
   logic                rd_en = 1'b0;
   logic                squash_valid = 1'b0;
   logic [SW-1:0]       squash_seq = '0;
   logic                busy, done, fault_out, held_valid;
   logic [IW-1:0]       held_idx;
   logic [SW-1:0]       held_seq;
   logic [CW-1:0]       viol_count;

   logic          m_ok   [DEPTH];
   logic [AW-1:0] m_addr [DEPTH];
   logic [SW-1:0] m_seq  [DEPTH];
   bit            mh_valid;
   int            mh_idx, mh_seq, m_count;
   int            n_chk, n_fail;
   bit            finished;

   always #2 clk = ~clk;

   always_comb begin
      for (int i = 0; i < DEPTH; i++) begin
         lq_addr_ok[i]        = m_ok[i];
         lq_addr[i*AW +: AW]  = m_addr[i];
         lq_seq[i*SW +: SW]   = m_seq[i];
      end
   end

   mem_order_guard u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_store(req_is_store),
      .req_idx(req_idx), .req_addr(req_addr), .req_ld_fault(req_ld_fault),
      .lq_tail(lq_tail), .lq_addr_ok(lq_addr_ok), .lq_addr(lq_addr), .lq_seq(lq_seq),
      .rd_en(rd_en), .squash_valid(squash_valid), .squash_seq(squash_seq),
      .busy(busy), .done(done), .fault_out(fault_out), .held_valid(held_valid),
      .held_idx(held_idx), .held_seq(held_seq), .viol_count(viol_count)
   );

   task automatic chk(string tag, string what, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   function automatic int nxt(int i);
      return (i + 1) % DEPTH;
   endfunction

   function automatic void predict(input bit st, input int idx, input logic [AW-1:0] a,
                                   output bit rec, output int ridx, output int passed);
      int cur;
      rec = 0; ridx = 0; passed = 0;
      cur = st ? idx : nxt(idx);
      for (int n = 0; n <= DEPTH; n++) begin
         if (cur == int'(lq_tail)) break;
         if (m_ok[cur] && (m_addr[cur] >> 8) == (a >> 8)) begin
            if (!mh_valid || int'(m_seq[cur]) < mh_seq) begin
               rec = 1; ridx = cur;
            end
            break;
         end
         passed++;
         cur = nxt(cur);
      end
   endfunction

   task automatic check_held(string tag);
      chk(tag, "held_valid", held_valid, mh_valid);
      if (mh_valid) begin
         chk(tag, "held_idx", held_idx, mh_idx);
         chk(tag, "held_seq", held_seq, mh_seq);
      end
   endtask

   task automatic run_req(bit st, int idx, logic [AW-1:0] a, bit flt, bit rd_same, string tag);
      bit rec;
      int ridx, passed, k_exp, k;
      if (flt && !st) begin
         rec = 0; ridx = 0; k_exp = 1;
      end else begin
         predict(st, idx, a, rec, ridx, passed);
         k_exp = passed + 2;
      end
      @(negedge clk);
      req_valid = 1'b1; req_is_store = st; req_idx = IW'(idx);
      req_addr = a; req_ld_fault = flt;
      @(negedge clk);
      req_valid = 1'b0;
      k = 1;
      if (rd_same) rd_en = 1'b1;
      while (!done && k < 64) begin
         @(negedge clk);
         rd_en = 1'b0;
         k++;
      end
      rd_en = 1'b0;
      if (rec) begin
         mh_valid = 1; mh_idx = ridx; mh_seq = int'(m_seq[ridx]);
         m_count = (m_count + 1) % (1 << CW);
      end else if (rd_same) begin
         mh_valid = 0;
      end
      chk(tag, "done latency (R10)", k, k_exp);
      chk(tag, "fault_out", fault_out, rec);
      check_held(tag);
      chk(tag, "viol_count", viol_count, m_count);
   endtask

   task automatic do_read(string tag);
      @(negedge clk);
      rd_en = 1'b1;
      check_held(tag);
      @(negedge clk);
      rd_en = 1'b0;
      mh_valid = 0;
      chk(tag, "held_valid after read", held_valid, 0);
   endtask

   task automatic do_squash(int s, string tag);
      @(negedge clk);
      squash_valid = 1'b1; squash_seq = SW'(s);
      @(negedge clk);
      squash_valid = 1'b0;
      if (mh_valid && s < mh_seq) mh_valid = 0;
      check_held(tag);
   endtask

   task automatic clear_q(int tail);
      for (int i = 0; i < DEPTH; i++) begin
         m_ok[i] = 1'b0; m_addr[i] = AW'(i) << 8; m_seq[i] = SW'(100 + i);
      end
      lq_tail = IW'(tail);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      clear_q(0);
      mh_valid = 0; m_count = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1", "busy", busy, 0);
      chk("R1", "done", done, 0);
      chk("R1", "fault_out", fault_out, 0);
      chk("R1", "held_valid", held_valid, 0);
      chk("R1", "viol_count", viol_count, 0);

      // R2/R4: load skips its own slot; low 8 bits differ but still conflict
      clear_q(6);
      m_ok[2] = 1; m_addr[2] = 32'h0000_5A10;
      m_ok[4] = 1; m_addr[4] = 32'h0000_5AFF;
      run_req(0, 2, 32'h0000_5A00, 0, 0, "R2");
      // R7: read returns then clears
      do_read("R7");
      // R2: store starts at its recorded slot inclusive
      run_req(1, 2, 32'h0000_5A00, 0, 0, "R2");

      // R5: held older blocks a younger hit, later older hit not reached
      clear_q(8);
      m_ok[3] = 1; m_addr[3] = 32'h0000_5A00; m_seq[3] = 300;
      m_ok[5] = 1; m_addr[5] = 32'h0000_5A00; m_seq[5] = 50;
      run_req(1, 3, 32'h0000_5A00, 0, 0, "R5");

      // R8: squash equal keeps, smaller clears
      do_squash(mh_seq, "R8");
      do_squash(mh_seq - 1, "R8");

      // R3: conflict sitting at the tail is not reported
      clear_q(5);
      m_ok[5] = 1; m_addr[5] = 32'h0000_5A00;
      m_ok[7] = 1; m_addr[7] = 32'h0000_5A00;
      run_req(0, 1, 32'h0000_5A00, 0, 0, "R3");

      // R4: address-valid flag low, other block different
      clear_q(6);
      m_ok[3] = 0; m_addr[3] = 32'h0000_5A00;
      m_ok[4] = 1; m_addr[4] = 32'h0000_5B00;
      run_req(1, 3, 32'h0000_5A00, 0, 0, "R4");

      // R2: wrap from last slot to slot 0
      clear_q(3);
      m_ok[0] = 1; m_addr[0] = 32'h0000_5A00;
      m_ok[15] = 1; m_addr[15] = 32'h0000_5A00;
      run_req(0, 15, 32'h0000_5A00, 0, 0, "R2");

      // R9: faulted load skips walk; fault flag has no effect on a store
      do_read("R7");
      run_req(0, 14, 32'h0000_5A00, 1, 0, "R9");
      run_req(1, 0, 32'h0000_5A00, 1, 0, "R9");

      // R11: read on the recording edge, new violator stays held
      clear_q(4);
      m_ok[1] = 1; m_addr[1] = 32'h0000_5A00; m_seq[1] = 20;
      run_req(1, 1, 32'h0000_5A00, 0, 1, "R11");

      // random rounds
      for (int it = 0; it < 300; it++) begin
         for (int i = 0; i < DEPTH; i++) begin
            m_ok[i]   = ($urandom % 4) != 0;
            m_addr[i] = (AW'($urandom % 3) << 8) | AW'($urandom % 256);
            m_seq[i]  = SW'($urandom % 1000);
         end
         lq_tail = IW'($urandom % DEPTH);
         run_req(bit'($urandom % 2), int'($urandom % DEPTH),
                 (AW'($urandom % 3) << 8) | AW'($urandom % 256),
                 ($urandom % 5) == 0, 0, "R6");
         if (($urandom % 4) == 0) do_read("R7");
         else if (($urandom % 5) == 0) do_squash(int'($urandom % 1000), "R8");
      end

      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule